// File: doc/BRIEF.md
# Two-Channel Capture Status and Count Readout Port

This block is the byte-wide register face of a two-channel event timer. The channel logic reports start, stop and counter-rollover events, and hands over a captured 16-bit count with a load strobe. The block turns those events into sticky status flags that software reads and clears in one access. It combines the flags with stored enables into one shared interrupt request, gated by a 2-bit priority field. It keeps the per-channel operating mode, and it stores each channel's 16-bit match value, written one byte at a time.

Each captured count is read as two bytes. A read of the low byte freezes the high byte in a holding latch, so a capture that lands between the two reads cannot mix halves from different events. Writing the status address with counter-reset bits set sends a one-cycle clear pulse to the channel counter and drops that channel's rollover flag.

Read data is combinational from the address. Side effects such as flag clearing and freezing take place at the clock edge that ends the read strobe. Addresses: 0 status, 1 control, 2 and 3 channel 1 low and high byte, 4 and 5 channel 2 low and high byte. Addresses 6 and 7 read as zero and ignore writes. When read and write strobes are both high, only the write takes effect.

Top module: `capture_reg_port`

## Requirements
- R1: After reset all flags, enables, modes, priority, match values and captured counts are zero, no freeze is pending, and `irq_req` is low.
- R2: An event input high at a clock edge sets its flag at that edge. The status byte (address 0) reads bit 7 channel 2 start, bit 6 channel 2 stop, bit 5 channel 1 start, bit 4 channel 1 stop, bit 3 channel 2 rollover, bit 2 channel 1 rollover, and bits 1:0 as zero.
- R3: A status read clears all six flags, except that a flag whose event is high in the same cycle stays set. The stored enables are not changed by the read.
- R4: A status write loads the enables from bits 7:4 (7 ch2 start, 6 ch2 stop, 5 ch1 start, 4 ch1 stop). A 1 in bit 3 (channel 2) or bit 2 (channel 1) drives that channel's `cnt_clear` bit high during the write cycle and clears its rollover flag unless a rollover event arrives in the same cycle. A 0 in those bits does nothing.
- R5: `irq_req` is high when the priority field is non-zero and either an enabled start or stop flag is set or any rollover flag is set. Rollover flags need no enable.
- R6: A control write (address 1) stores bit 7 as channel 2 mode and bit 6 as channel 1 mode (1 = count, 0 = capture) on `count_mode[1]` and `count_mode[0]`, and bits 1:0 as the priority. A control read returns the mode bits in 7:6, zeros in 5:2 and the priority in 1:0.
- R7: A low-byte read returns the captured count bits 7:0 and freezes bits 15:8. The next high-byte read returns the frozen byte and releases the freeze. Captures arriving in between still update the live count.
- R8: A high-byte read with no freeze pending returns the live captured count bits 15:8.
- R9: Writes to a channel's low and high addresses store bits 7:0 and 15:8 of its match value, which is visible on `match_value` after the edge.
- R10: `irq_level` always equals the stored priority field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| ev_start | input | 2 | Start event per channel |
| ev_stop | input | 2 | Stop event per channel |
| ev_roll | input | 2 | Counter rollover event per channel |
| cap_load | input | 2 | Captured count valid per channel |
| cap_value | input | 32 | Captured counts, channel 1 in bits 15:0 |
| cnt_clear | output | 2 | Counter reset pulse per channel |
| count_mode | output | 2 | Count (1) or capture (0) per channel |
| match_value | output | 32 | Match values, channel 1 in bits 15:0 |
| irq_req | output | 1 | Shared interrupt request |
| irq_level | output | 2 | Interrupt priority, 00 = disabled |

## Verification
The bench uses the default byte width of 8, which gives a 16-bit count per channel. With this width a low byte and its frozen high byte are easy to tell apart. A reference model that tracks flags, enables, freeze state and match bytes cycle by cycle is compared against the read data, the interrupt request, the clear pulses, the modes and the match outputs. Random traffic often places events in the same cycle as status reads and counter resets, and often puts captures between low and high reads. Directed sequences cover priority masking and the rollover path, which needs no enable.

// File: rtl/capreg_pkg.sv
package capreg_pkg;
  localparam int unsigned NCH    = 2;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;

  // byte addresses of a channel's count / match halves
  function automatic logic [ADDR_W-1:0] lo_addr(input int unsigned ch);
    return ADDR_W'(2 + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int unsigned ch);
    return ADDR_W'(3 + 2 * ch);
  endfunction

  // status byte layout
  function automatic logic [7:0] pack_status(input logic [1:0] st,
                                             input logic [1:0] sp,
                                             input logic [1:0] ro);
    return {st[1], sp[1], st[0], sp[0], ro[1], ro[0], 2'b00};
  endfunction

  // en: [3] ch2 start, [2] ch2 stop, [1] ch1 start, [0] ch1 stop
  function automatic logic irq_eval(input logic [1:0] st,
                                    input logic [1:0] sp,
                                    input logic [1:0] ro,
                                    input logic [3:0] en,
                                    input logic [1:0] prio);
    logic [3:0] ev;
    ev = {st[1], sp[1], st[0], sp[0]};
    return (prio != 2'b00) && ((|(ev & en)) || (|ro));
  endfunction
endpackage

// File: rtl/capreg_status.sv
module capreg_status
  import capreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ev_start,
  input  logic [1:0] ev_stop,
  input  logic [1:0] ev_roll,
  input  logic       rd_stat,
  input  logic       wr_stat,
  input  logic [5:0] wr_bits,   // bus bits 7:2
  input  logic [1:0] prio,
  output logic [7:0] stat_byte,
  output logic [1:0] cnt_clear,
  output logic       irq_req
);
  logic [1:0] start_q, stop_q, roll_q;
  logic [3:0] en_q;
  logic       flag_clear;
  logic [1:0] roll_clear;

  assign flag_clear = rd_stat;
  assign cnt_clear  = wr_stat ? wr_bits[1:0] : 2'b00;
  assign roll_clear = flag_clear ? 2'b11 : cnt_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
      roll_q  <= '0;
      en_q    <= '0;
    end else begin
      start_q <= ev_start | (flag_clear ? 2'b00 : start_q);
      stop_q  <= ev_stop  | (flag_clear ? 2'b00 : stop_q);
      roll_q  <= ev_roll  | (roll_q & ~roll_clear);
      if (wr_stat) en_q <= wr_bits[5:2];
    end
  end

  assign stat_byte = pack_status(start_q, stop_q, roll_q);
  assign irq_req   = irq_eval(start_q, stop_q, roll_q, en_q, prio);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start[i] |=> start_q[i]);
    // R2
    roll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_roll[i] |=> roll_q[i]);
    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat && !ev_stop[i] |=> !stop_q[i]);
    // R4
    cnt_reset_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clear[i] && !ev_roll[i] |=> !roll_q[i]);
  end

  // R5
  irq_needs_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> prio != 2'b00);
endmodule

// File: rtl/capreg_ctrl.sv
module capreg_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [1:0] wr_mode,   // bus bits 7:6
  input  logic [1:0] wr_prio,   // bus bits 1:0
  output logic [1:0] count_mode,
  output logic [1:0] prio,
  output logic [7:0] ctrl_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_mode <= '0;
      prio       <= '0;
    end else if (wr_ctrl) begin
      count_mode <= wr_mode;
      prio       <= wr_prio;
    end
  end

  assign ctrl_byte = {count_mode, 4'b0000, prio};

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(prio) && $stable(count_mode));
endmodule

// File: rtl/capreg_chan.sv
module capreg_chan #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_load,
  input  logic [2*BYTE_W-1:0] cap_value,
  input  logic                rd_lo,
  input  logic                rd_hi,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   lo_byte,
  output logic [BYTE_W-1:0]   hi_byte,
  output logic [2*BYTE_W-1:0] match
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  hold_q;
  logic [BYTE_W-1:0] msb_frz;
  logic              frz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      msb_frz <= '0;
      frz_q   <= 1'b0;
      match   <= '0;
    end else begin
      if (rd_lo) begin
        msb_frz <= hold_q[CNT_W-1:BYTE_W];
        frz_q   <= 1'b1;
      end else if (rd_hi) begin
        frz_q   <= 1'b0;
      end
      if (cap_load) hold_q <= cap_value;
      if (wr_lo) match[BYTE_W-1:0]     <= wdata;
      if (wr_hi) match[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  assign lo_byte = hold_q[BYTE_W-1:0];
  assign hi_byte = frz_q ? msb_frz : hold_q[CNT_W-1:BYTE_W];

  // R7
  freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> frz_q);
  // R7
  freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !rd_lo |=> $stable(msb_frz));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && !rd_lo |=> !frz_q);
  // R9
  match_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> match[BYTE_W-1:0] == $past(wdata));
endmodule

// File: rtl/capture_reg_port.sv
module capture_reg_port
  import capreg_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic [NCH-1:0]            ev_start,
  input  logic [NCH-1:0]            ev_stop,
  input  logic [NCH-1:0]            ev_roll,
  input  logic [NCH-1:0]            cap_load,
  input  logic [NCH*2*BYTE_W-1:0]   cap_value,
  output logic [NCH-1:0]            cnt_clear,
  output logic [NCH-1:0]            count_mode,
  output logic [NCH*2*BYTE_W-1:0]   match_value,
  output logic                      irq_req,
  output logic [1:0]                irq_level
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic              rd_eff;
  logic              rd_stat, wr_stat, wr_ctrl;
  logic [7:0]        stat_byte, ctrl_byte;
  logic [1:0]        prio;
  logic [BYTE_W-1:0] lo_byte [NCH];
  logic [BYTE_W-1:0] hi_byte [NCH];

  assign rd_eff  = bus_rd && !bus_wr;
  assign rd_stat = rd_eff && (bus_addr == A_STAT);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  capreg_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .ev_roll   (ev_roll),
    .rd_stat   (rd_stat),
    .wr_stat   (wr_stat),
    .wr_bits   (bus_wdata[7:2]),
    .prio      (prio),
    .stat_byte (stat_byte),
    .cnt_clear (cnt_clear),
    .irq_req   (irq_req)
  );

  capreg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_mode    (bus_wdata[7:6]),
    .wr_prio    (bus_wdata[1:0]),
    .count_mode (count_mode),
    .prio       (prio),
    .ctrl_byte  (ctrl_byte)
  );

  assign irq_level = prio;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_lo, sel_hi;
    assign sel_lo = (bus_addr == lo_addr(c));
    assign sel_hi = (bus_addr == hi_addr(c));

    capreg_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_load  (cap_load[c]),
      .cap_value (cap_value[c*CNT_W +: CNT_W]),
      .rd_lo     (rd_eff && sel_lo),
      .rd_hi     (rd_eff && sel_hi),
      .wr_lo     (bus_wr && sel_lo),
      .wr_hi     (bus_wr && sel_hi),
      .wdata     (bus_wdata),
      .lo_byte   (lo_byte[c]),
      .hi_byte   (hi_byte[c]),
      .match     (match_value[c*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata = BYTE_W'(stat_byte);
    if (bus_addr == A_CTRL) bus_rdata = BYTE_W'(ctrl_byte);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == lo_addr(c)) bus_rdata = lo_byte[c];
      if (bus_addr == hi_addr(c)) bus_rdata = hi_byte[c];
    end
  end

  // R10
  level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> irq_level == $past(bus_wdata[1:0]));
  // R4
  clear_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> cnt_clear == '0);
endmodule

// File: tb/test_capture_reg_port.sv
module test_capture_reg_port;
  localparam int BW = 8;
  localparam int CW = 2 * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic [1:0]    ev_start = '0, ev_stop = '0, ev_roll = '0, cap_load = '0;
  logic [2*CW-1:0] cap_value = '0;
  logic [1:0]    cnt_clear, count_mode, irq_level;
  logic [2*CW-1:0] match_value;
  logic          irq_req;

  always #2 clk = ~clk;  // 250 MHz

  capture_reg_port #(.BYTE_W(BW)) i_capture_reg_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_roll(ev_roll),
    .cap_load(cap_load), .cap_value(cap_value), .cnt_clear(cnt_clear),
    .count_mode(count_mode), .match_value(match_value),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  // reference model
  logic [1:0]    mst, msp, mro, mmode, mprio, mfrz;
  logic [3:0]    men;
  logic [CW-1:0] mhold [2];
  logic [CW-1:0] mmatch [2];
  logic [BW-1:0] mmsb [2];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {mst[1], msp[1], mst[0], msp[0], mro[1], mro[0], 2'b00};
  endfunction

  function automatic logic exp_irq();
    logic enabled_hit;
    enabled_hit = (mst[1] & men[3]) | (msp[1] & men[2]) | (mst[0] & men[1]) | (msp[0] & men[0]);
    return (mprio != 0) && (enabled_hit || mro != 0);
  endfunction

  function automatic logic [BW-1:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return exp_status();
      3'd1: return {mmode[1], mmode[0], 4'b0000, mprio};
      3'd2: return mhold[0][BW-1:0];
      3'd3: return mfrz[0] ? mmsb[0] : mhold[0][CW-1:BW];
      3'd4: return mhold[1][BW-1:0];
      3'd5: return mfrz[1] ? mmsb[1] : mhold[1][CW-1:BW];
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    mst = 0; msp = 0; mro = 0; mmode = 0; mprio = 0; mfrz = 0; men = 0;
    for (int c = 0; c < 2; c++) begin
      mhold[c] = 0; mmatch[c] = 0; mmsb[c] = 0;
    end
  endtask

  task automatic model_step();
    logic rd;
    logic [1:0] rclr;
    rd = bus_rd && !bus_wr;
    rclr = (rd && bus_addr == 0) ? 2'b11 :
           (bus_wr && bus_addr == 0) ? {bus_wdata[3], bus_wdata[2]} : 2'b00;
    mst = ev_start | ((rd && bus_addr == 0) ? 2'b00 : mst);
    msp = ev_stop  | ((rd && bus_addr == 0) ? 2'b00 : msp);
    mro = ev_roll  | (mro & ~rclr);
    if (bus_wr && bus_addr == 0) men = bus_wdata[7:4];
    if (bus_wr && bus_addr == 1) begin
      mmode = {bus_wdata[7], bus_wdata[6]};
      mprio = bus_wdata[1:0];
    end
    for (int c = 0; c < 2; c++) begin
      if (rd && bus_addr == 3'(2 + 2 * c)) begin
        mfrz[c] = 1'b1;
        mmsb[c] = mhold[c][CW-1:BW];
      end else if (rd && bus_addr == 3'(3 + 2 * c)) begin
        mfrz[c] = 1'b0;
      end
      if (cap_load[c]) mhold[c] = cap_value[c*CW +: CW];
      if (bus_wr && bus_addr == 3'(2 + 2 * c)) mmatch[c][BW-1:0] = bus_wdata;
      if (bus_wr && bus_addr == 3'(3 + 2 * c)) mmatch[c][CW-1:BW] = bus_wdata;
    end
  endtask

  // inputs are set at the falling edge; checks run 1 ns later, before the rising edge
  task automatic cycle();
    string rq;
    #1;
    chk("R5 irq_req", irq_req, exp_irq());
    chk("R10 irq_level", irq_level, mprio);
    chk("R6 count_mode", count_mode, mmode);
    chk("R9 match_value", match_value, {mmatch[1], mmatch[0]});
    chk("R4 cnt_clear", cnt_clear,
        (bus_wr && bus_addr == 0) ? {bus_wdata[3], bus_wdata[2]} : 2'b00);
    if (bus_rd && !bus_wr) begin
      case (bus_addr)
        3'd0: rq = "R2/R3 status read";
        3'd1: rq = "R6 control read";
        3'd2, 3'd4: rq = "R7 low byte read";
        3'd3: rq = mfrz[0] ? "R7 frozen high read" : "R8 live high read";
        3'd5: rq = mfrz[1] ? "R7 frozen high read" : "R8 live high read";
        default: rq = "R2 unused address read";
      endcase
      chk(rq, bus_rdata, exp_rdata(bus_addr));
    end
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; ev_start = 0; ev_stop = 0; ev_roll = 0; cap_load = 0;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cycle();
  endtask

  task automatic do_rd(input logic [2:0] a);
    bus_addr = a; bus_rd = 1; cycle();
  endtask

  task automatic do_cap(input int c, input logic [15:0] v);
    cap_load[c] = 1'b1; cap_value[c*CW +: CW] = v; cycle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    model_reset();
    @(negedge clk);
    repeat (3) cycle();
    rst_n = 1;
    // R1: reset state
    chk("R1 irq low after reset", irq_req, 1'b0);
    for (int a = 0; a < 8; a++) do_rd(3'(a));

    // R2/R3/R5: single event, enables, same-cycle read and event
    do_wr(3'd1, 8'h01);
    do_wr(3'd0, 8'h20);                 // enable ch1 start only
    ev_start[0] = 1; cycle();
    chk("R5 irq after enabled start", irq_req, 1'b1);
    bus_addr = 0; bus_rd = 1; ev_stop[1] = 1; cycle();  // R3 event wins
    do_rd(3'd0);
    do_rd(3'd0);
    // R5: rollover needs no enable, priority 00 masks
    do_wr(3'd0, 8'h00);
    ev_roll[1] = 1; cycle();
    chk("R5 rollover irq", irq_req, 1'b1);
    do_wr(3'd1, 8'hC0);
    chk("R5 prio 00 masks", irq_req, 1'b0);
    // R4: counter reset clears rollover, zero bits do nothing
    do_wr(3'd0, 8'h00);
    do_rd(3'd0);
    ev_roll = 2'b11; cycle();
    do_wr(3'd0, 8'h08);
    do_rd(3'd0);
    // R7/R8: freeze across a capture
    do_cap(0, 16'h1234);
    do_rd(3'd2);
    do_cap(0, 16'hABCD);
    bus_addr = 3; bus_rd = 1; #1;
    chk("R7 frozen high byte", bus_rdata, 8'h12);
    cycle();
    do_rd(3'd3);
    chk("R8 live high byte", exp_rdata(3'd3), 8'hAB);
    do_rd(3'd2);
    // R9: match bytes
    do_wr(3'd4, 8'h5A); do_wr(3'd5, 8'hC3);
    do_wr(3'd2, 8'h11); do_wr(3'd3, 8'h22);
    cycle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      ev_start = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      ev_stop  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      ev_roll  = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
      cap_load = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      cap_value = 32'($urandom);
      op = $urandom % 8;
      bus_addr = 3'($urandom);
      bus_wdata = 8'($urandom);
      if (op < 4) bus_rd = 1;
      else if (op < 6) bus_wr = 1;
      else if (op == 6) begin bus_rd = 1; bus_wr = 1; end
      cycle();
    end
    finish_run();
  end
endmodule